// File: doc/BRIEF.md
# Clock Source Switching Controller

This block decides which oscillator drives the system clock in run mode. It chooses between a primary oscillator and an internal oscillator block. It drives the two gate enables of a glitch-free clock multiplexer and keeps two status flags that tell software which source is in use. The analog oscillators, the PLL and the gating cells sit outside the block. Each oscillator shows up here only as an enable, a ready indication or a one-cycle tick pulse per period of its clock. All logic runs on a free-running controller clock.

The select fields arrive from another clock domain and pass through a synchronizer first. A request for the primary source starts the primary oscillator. The block then counts a fixed number of primary periods before it hands the multiplexer over. Until that count finishes, the internal path keeps clocking the device. The handover first turns the old gate off and then counts a few periods of the new clock before it turns the new gate on. If a new request arrives while the start-up count is running, the count is dropped and starts again for the source now requested.

Top module: `clksw_ctrl`

## Requirements
- R1: While reset is asserted, `mux_int_en` is 1 and `mux_pri_en`, `int_stable` and `pri_started` are 0. The start-up count is cleared.
- R2: When `int_freq_sel` is 0 and `int_src_bit` is 0 (after synchronization), `fast_int_en` is 0 and `int_stable` stays 0.
- R3: `int_stable` is 1 only when the fast internal oscillator is enabled, `int_osc_ready` is 1 and the internal path drives the device. Once all three conditions hold, it becomes 1.
- R4: If `int_stable` is already 1 when a switch to the primary source is requested, it stays 1 without a gap until that switch completes.
- R5: After a request for the primary source, `pri_osc_en` goes to 1. `mux_pri_en` cannot rise before OST_CYCLES (default 1024) `pri_tick` pulses have been counted. `mux_int_en` stays 1 while that count runs.
- R6: When the switch to the primary source completes, `mux_pri_en` rises, `pri_started` rises and `int_stable` falls, all at the same clock edge.
- R7: `mux_pri_en` and `mux_int_en` are never 1 together. The new gate rises 2 to 4 ticks of the new clock after the old gate falls.
- R8: `slow_rc_en` is 1 whenever `wdt_en` or `fscm_en` is 1. It is also 1 when the internal path drives the device with the fast internal oscillator disabled.
- R9: If the internal source is requested again while a start-up count runs, the switch is abandoned: `pri_osc_en` returns to 0 and `mux_pri_en` stays 0. A later request for the primary source waits a full OST_CYCLES count again.
- R10: On a switch from the primary source to the internal source, `pri_started` is 0 by the time `mux_int_en` rises.
- R11: Source select encoding: `clk_src_sel` values 2'b10 and 2'b11 select the internal source, and 2'b00 and 2'b01 select the primary source. The fast internal oscillator is enabled when `int_freq_sel` is nonzero or `int_src_bit` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_src_sel | input | 2 | Requested system clock source (asynchronous) |
| int_freq_sel | input | 3 | Internal frequency select; nonzero turns on the fast internal oscillator |
| int_src_bit | input | 1 | Forces the fast internal oscillator on |
| pri_tick | input | 1 | One pulse per primary oscillator period |
| int_tick | input | 1 | One pulse per internal oscillator period |
| int_osc_ready | input | 1 | Fast internal oscillator reports stable (asynchronous) |
| wdt_en | input | 1 | Watchdog enabled |
| fscm_en | input | 1 | Fail-safe clock monitor enabled |
| mux_pri_en | output | 1 | Gate enable of the primary leg of the clock multiplexer |
| mux_int_en | output | 1 | Gate enable of the internal leg of the clock multiplexer |
| int_stable | output | 1 | Fast internal clock is stable and drives the device |
| pri_started | output | 1 | Primary start-up count done and primary clock in use |
| slow_rc_en | output | 1 | Keep-alive enable of the slow internal RC oscillator |
| fast_int_en | output | 1 | Enable of the fast internal oscillator |
| pri_osc_en | output | 1 | Enable of the primary oscillator |

## Verification
The bench runs the primary tick at half rate to test the start-up count. A design that counted controller cycles instead of primary periods would hand over about 500 ticks too early. The bench also checks that `int_stable` never drops while the count runs and that it clears at the same edge where `pri_started` sets. A flag with a gap, or a clear one edge late, would show up as a miscompare. The bench reverses a pending request partway through the count and then measures the full wait on the next request, which catches a counter that resumes instead of restarting. On both handovers it counts new-clock ticks between the old gate falling and the new gate rising. This catches an overlap of the two gates and a handover delay outside the 2-to-4-tick window.

// File: rtl/clksw_pkg.sv
package clksw_pkg;

   typedef enum logic [2:0] {
      ST_RUN_INT  = 3'd0,
      ST_WAIT_OST = 3'd1,
      ST_HAND_PRI = 3'd2,
      ST_RUN_PRI  = 3'd3,
      ST_HAND_INT = 3'd4
   } clksw_state_e;

   // 2'b1x requests the internal source, anything else the primary source
   function automatic logic sel_wants_int(input logic [1:0] sel);
      return (sel == 2'b10) || (sel == 2'b11);
   endfunction

   // states in which the internal leg still clocks the device
   function automatic logic on_int_path(input clksw_state_e st);
      return (st == ST_RUN_INT) || (st == ST_WAIT_OST) || (st == ST_HAND_PRI);
   endfunction

endpackage

// File: rtl/clksw_sync.sv
module clksw_sync #(
   parameter int          W       = 1,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [STAGES-1:0][W-1:0] stg;

   initial begin
      assert (STAGES >= 2) else $error("clksw_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= {STAGES{RST_VAL}};
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/clksw_tick_cnt.sv
module clksw_tick_cnt #(
   parameter int LIMIT = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic tick,
   output logic done
);

   localparam int          CW  = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LIM = CW'(LIMIT);

   logic [CW-1:0] cnt;

   initial begin
      assert (LIMIT >= 1) else $error("clksw_tick_cnt: LIMIT must be positive");
   end

   // clears whenever run drops, so a fresh run always counts the full LIMIT
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt <= '0;
      else if (!run)              cnt <= '0;
      else if (tick && cnt != LIM) cnt <= cnt + CW'(1);
   end

   assign done = (cnt == LIM);

endmodule

// File: rtl/clksw_status.sv
module clksw_status
   import clksw_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  clksw_state_e state_d,
   input  logic         fast_on,
   input  logic         int_rdy,
   output logic         mux_pri_en,
   output logic         mux_int_en,
   output logic         int_stable,
   output logic         pri_started
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mux_pri_en  <= 1'b0;
         mux_int_en  <= 1'b1;
         int_stable  <= 1'b0;
         pri_started <= 1'b0;
      end else begin
         mux_int_en  <= (state_d == ST_RUN_INT) || (state_d == ST_WAIT_OST);
         mux_pri_en  <= (state_d == ST_RUN_PRI);
         int_stable  <= fast_on && int_rdy && on_int_path(state_d);
         pri_started <= (state_d == ST_RUN_PRI);
      end
   end

endmodule

// File: rtl/clksw_ctrl.sv
module clksw_ctrl
   import clksw_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int OST_CYCLES  = 1024,
   parameter int HAND_TICKS  = 2,
   parameter bit READY_SYNC  = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] clk_src_sel,
   input  logic [2:0] int_freq_sel,
   input  logic       int_src_bit,
   input  logic       pri_tick,
   input  logic       int_tick,
   input  logic       int_osc_ready,
   input  logic       wdt_en,
   input  logic       fscm_en,
   output logic       mux_pri_en,
   output logic       mux_int_en,
   output logic       int_stable,
   output logic       pri_started,
   output logic       slow_rc_en,
   output logic       fast_int_en,
   output logic       pri_osc_en
);

   localparam int SYNC_W = 6;

   initial begin
      assert (HAND_TICKS >= 2 && HAND_TICKS <= 4)
         else $error("clksw_ctrl: HAND_TICKS must lie in 2..4");
      assert (OST_CYCLES >= 2) else $error("clksw_ctrl: OST_CYCLES too small");
   end

   logic [SYNC_W-1:0] sel_bus_s;
   logic [1:0]        src_s;
   logic [2:0]        freq_s;
   logic              isrc_s;
   logic              rdy_s;
   logic              want_int;
   logic              fast_on;

   clksw_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sel_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({clk_src_sel, int_freq_sel, int_src_bit}),
      .q     (sel_bus_s)
   );

   assign {src_s, freq_s, isrc_s} = sel_bus_s;

   generate
      if (READY_SYNC) begin : g_rdy_sync
         clksw_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rdy_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (int_osc_ready),
            .q     (rdy_s)
         );
      end else begin : g_rdy_raw
         assign rdy_s = int_osc_ready;
      end
   endgenerate

   assign want_int = sel_wants_int(src_s);
   assign fast_on  = (freq_s != 3'd0) || isrc_s;

   clksw_state_e state_q, state_d;
   logic         ost_run, ost_done;
   logic         hand_run, hand_tick, hand_done;

   assign ost_run   = (state_q == ST_WAIT_OST);
   assign hand_run  = (state_q == ST_HAND_PRI) || (state_q == ST_HAND_INT);
   assign hand_tick = (state_q == ST_HAND_PRI) ? pri_tick : int_tick;

   clksw_tick_cnt #(.LIMIT(OST_CYCLES)) u_ost (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (ost_run),
      .tick  (pri_tick),
      .done  (ost_done)
   );

   clksw_tick_cnt #(.LIMIT(HAND_TICKS)) u_hand (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (hand_run),
      .tick  (hand_tick),
      .done  (hand_done)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_RUN_INT:  if (!want_int) state_d = ST_WAIT_OST;
         ST_WAIT_OST: begin
            if (want_int)      state_d = ST_RUN_INT;
            else if (ost_done) state_d = ST_HAND_PRI;
         end
         ST_HAND_PRI: if (hand_done) state_d = ST_RUN_PRI;
         ST_RUN_PRI:  if (want_int)  state_d = ST_HAND_INT;
         ST_HAND_INT: if (hand_done) state_d = ST_RUN_INT;
         default:     state_d = ST_RUN_INT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_RUN_INT;
      else        state_q <= state_d;
   end

   clksw_status u_status (
      .clk         (clk),
      .rst_n       (rst_n),
      .state_d     (state_d),
      .fast_on     (fast_on),
      .int_rdy     (rdy_s),
      .mux_pri_en  (mux_pri_en),
      .mux_int_en  (mux_int_en),
      .int_stable  (int_stable),
      .pri_started (pri_started)
   );

   assign fast_int_en = fast_on;
   assign pri_osc_en  = (state_q != ST_RUN_INT);
   assign slow_rc_en  = wdt_en || fscm_en || ((state_q != ST_RUN_PRI) && !fast_on);

endmodule

// File: rtl/clksw_ctrl_chk.sv
module clksw_ctrl_chk #(
   parameter int OST_CYCLES = 1024
) (
   input logic clk,
   input logic rst_n,
   input logic pri_tick,
   input logic wdt_en,
   input logic fscm_en,
   input logic mux_pri_en,
   input logic mux_int_en,
   input logic int_stable,
   input logic pri_started,
   input logic slow_rc_en,
   input logic fast_int_en,
   input logic pri_osc_en
);

   localparam int          CW  = $clog2(OST_CYCLES + 1);
   localparam logic [CW-1:0] LIM = CW'(OST_CYCLES);

   logic [CW-1:0] seen_ticks;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            seen_ticks <= '0;
      else if (!pri_osc_en)                  seen_ticks <= '0;
      else if (pri_tick && seen_ticks != LIM) seen_ticks <= seen_ticks + CW'(1);
   end

   // R7
   gate_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mux_pri_en && mux_int_en));

   // R7
   pri_bbm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mux_pri_en) |-> $past(!mux_int_en));

   // R5
   ost_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mux_pri_en) |-> (seen_ticks == LIM));

   // R6
   flag_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pri_started) |-> (!int_stable && mux_pri_en));

   // R3
   stable_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int_stable |-> $past(fast_int_en));

   // R8
   keep_alive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wdt_en || fscm_en) |-> slow_rc_en);

   // R10
   int_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mux_int_en) |-> !pri_started);

endmodule

bind clksw_ctrl clksw_ctrl_chk #(.OST_CYCLES(OST_CYCLES)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .pri_tick    (pri_tick),
   .wdt_en      (wdt_en),
   .fscm_en     (fscm_en),
   .mux_pri_en  (mux_pri_en),
   .mux_int_en  (mux_int_en),
   .int_stable  (int_stable),
   .pri_started (pri_started),
   .slow_rc_en  (slow_rc_en),
   .fast_int_en (fast_int_en),
   .pri_osc_en  (pri_osc_en)
);

// File: tb/clksw_ctrl_tb.sv
module clksw_ctrl_tb;

   localparam int CLK_PERIOD = 10;
   localparam int OST        = 1024;
   localparam int SETTLE     = 1100;
   localparam int WD_CYCLES  = 150000;
   localparam int NVEC       = 10;

   // {sel[1:0], freq[2:0], isrc, rdy, wdt, fscm} | {pri, int, stable, started, slow, fast}
   localparam logic [14:0] VEC [NVEC] = '{
      15'b00_000_0000_100100,
      15'b10_000_0000_010010,
      15'b10_011_0100_011001,
      15'b10_011_0000_010001,
      15'b10_000_1100_011001,
      15'b00_000_1110_100111,
      15'b01_101_0101_100111,
      15'b11_101_0100_011001,
      15'b11_000_0100_010010,
      15'b00_000_0000_100100
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] clk_src_sel = 2'b00;
   logic [2:0] int_freq_sel = 3'd0;
   logic       int_src_bit = 1'b0;
   logic       pri_tick = 1'b1;
   logic       int_tick = 1'b1;
   logic       int_osc_ready = 1'b0;
   logic       wdt_en = 1'b0;
   logic       fscm_en = 1'b0;
   logic       mux_pri_en, mux_int_en, int_stable, pri_started;
   logic       slow_rc_en, fast_int_en, pri_osc_en;
   logic       slow_tick = 1'b0;
   logic       seen_pri = 1'b0;
   int         n_chk = 0;
   int         n_bad = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   always @(negedge clk) pri_tick <= slow_tick ? ~pri_tick : 1'b1;
   always @(posedge clk) seen_pri <= pri_tick;

   clksw_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .clk_src_sel(clk_src_sel), .int_freq_sel(int_freq_sel),
      .int_src_bit(int_src_bit), .pri_tick(pri_tick), .int_tick(int_tick),
      .int_osc_ready(int_osc_ready), .wdt_en(wdt_en), .fscm_en(fscm_en),
      .mux_pri_en(mux_pri_en), .mux_int_en(mux_int_en), .int_stable(int_stable),
      .pri_started(pri_started), .slow_rc_en(slow_rc_en), .fast_int_en(fast_int_en),
      .pri_osc_en(pri_osc_en)
   );

   task automatic chk(input logic ok, input string tag, input int got, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic summary;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not finish, got %0d expected %0d", WD_CYCLES, 0);
      summary();
      $finish;
   end

   initial begin
      logic [5:0] obs;
      int         ticks, htick, cyc;
      logic       fell, both, early, gap, ok_rise;

      // R1: reset state
      wait_cyc(3);
      chk({mux_pri_en, mux_int_en, int_stable, pri_started} == 4'b0100,
          "R1 reset outputs", {mux_pri_en, mux_int_en, int_stable, pri_started}, 4'b0100);
      rst_n = 1'b1;

      // vector table: R2 R3 R8 R11 settled behaviour
      for (int v = 0; v < NVEC; v++) begin
         @(negedge clk);
         {clk_src_sel, int_freq_sel, int_src_bit, int_osc_ready, wdt_en, fscm_en} = VEC[v][14:6];
         wait_cyc(SETTLE);
         obs = {mux_pri_en, mux_int_en, int_stable, pri_started, slow_rc_en, fast_int_en};
         chk(obs == VEC[v][5:0], $sformatf("R2 R3 R8 R11 vector %0d", v), obs, VEC[v][5:0]);
      end

      // R10 R7: primary to internal handover
      @(negedge clk);
      clk_src_sel = 2'b10; int_freq_sel = 3'd3; int_osc_ready = 1'b1;
      fell = 1'b0; htick = 0; both = 1'b0; ok_rise = 1'b0;
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (fell) htick++;
         if (mux_pri_en && mux_int_en) both = 1'b1;
         if (mux_int_en) begin ok_rise = !pri_started; break; end
         if (!mux_pri_en) fell = 1'b1;
      end
      chk(ok_rise, "R10 pri_started clear at internal select", pri_started, 0);
      chk(htick >= 2 && htick <= 4, "R7 handover ticks to internal", htick, 3);
      chk(!both, "R7 gates overlap to internal", both, 0);
      wait_cyc(10);
      chk(int_stable, "R3 stable flag set on internal", int_stable, 1);

      // R9: abandon a pending switch, then full restart
      @(negedge clk);
      clk_src_sel = 2'b00;
      wait_cyc(500);
      chk({pri_osc_en, mux_int_en, mux_pri_en} == 3'b110, "R5 still on internal mid count",
          {pri_osc_en, mux_int_en, mux_pri_en}, 3'b110);
      clk_src_sel = 2'b10;
      wait_cyc(10);
      chk({pri_osc_en, mux_int_en, mux_pri_en} == 3'b010, "R9 pending switch abandoned",
          {pri_osc_en, mux_int_en, mux_pri_en}, 3'b010);
      clk_src_sel = 2'b00;
      cyc = 0;
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         cyc++;
         if (mux_pri_en) break;
      end
      chk(cyc >= OST && cyc <= OST + 10, "R9 count restarted in full", cyc, OST + 6);

      // back to internal, stable, for the slow-tick start-up test
      @(negedge clk);
      clk_src_sel = 2'b10;
      wait_cyc(20);
      chk(int_stable && mux_int_en, "R3 stable flag before switch", int_stable, 1);

      // R5 R4 R6 R7: half-rate primary ticks
      slow_tick = 1'b1;
      @(negedge clk);
      clk_src_sel = 2'b00;
      ticks = 0; htick = 0; fell = 1'b0; both = 1'b0; early = 1'b0; gap = 1'b0; ok_rise = 1'b0;
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         ticks += int'(seen_pri);
         if (fell) htick += int'(seen_pri);
         if (mux_pri_en && mux_int_en) both = 1'b1;
         if (mux_pri_en) begin ok_rise = pri_started && !int_stable; break; end
         if (!int_stable) gap = 1'b1;
         if (ticks < OST && !mux_int_en) early = 1'b1;
         if (!mux_int_en) fell = 1'b1;
      end
      chk(ticks >= OST && ticks <= OST + 16, "R5 primary ticks before select", ticks, OST + 4);
      chk(!early, "R5 internal gate held during count", early, 0);
      chk(!gap, "R4 stable flag without gap", gap, 0);
      chk(ok_rise, "R6 flags swap at completion", {pri_started, int_stable}, 2'b10);
      chk(htick >= 2 && htick <= 4, "R7 handover ticks to primary", htick, 2);
      chk(!both, "R7 gates overlap to primary", both, 0);
      slow_tick = 1'b0;

      // R8: keep-alive follows watchdog on primary
      @(negedge clk);
      wdt_en = 1'b1;
      @(negedge clk);
      chk(slow_rc_en, "R8 keep-alive with watchdog on primary", slow_rc_en, 1);
      wdt_en = 1'b0;
      @(negedge clk);
      chk(!slow_rc_en, "R8 keep-alive off on primary", slow_rc_en, 0);

      summary();
      $finish;
   end

endmodule